// File: doc/BRIEF.md
# PLL clock frequency calculator

This unit turns three control words (a mode word, a main PLL control word and a post-divider word) into the frequencies, in Hz, of three derived clocks. The three clocks are the processor clock, a high-speed clock and a peripheral bus clock. A one-cycle start pulse captures the three words. The unit first picks a reference frequency. It then either passes that reference straight through or evaluates a fractional-N PLL equation. The equation has a signed numerator, a clamped integer factor and a scaling by 1024. Two cascaded integer post-dividers follow.

All arithmetic runs on a single shared restoring divider that produces one quotient bit per cycle. The PLL quotient, the high-speed quotient and the bus quotient are computed one after another. When all three results are valid, a one-cycle done pulse is raised. Timer and peripheral models use the results to learn their tick rates whenever the clock configuration changes.

Top module: `pllfreq_calc`

## Requirements
- R1: After reset, `busy` and `done` are low and all three frequency outputs are zero.
- R2: The reference is 33,554,432 Hz when mode bits 2:1 hold the value 2. For any other value of that field it is 26,000,000 Hz.
- R3: When mode bit 7 is set or mode bit 3 is clear, the processor frequency equals the reference and the PLL is bypassed.
- R4: PLL fields are decoded as follows. The integer factor is PLL bits 13:10, raised to 5 when it is below 5. The numerator is PLL bits 9:0 read as a 10-bit two's-complement value. The denominator is PLL bits 25:16 plus 1. The pre-divider is PLL bits 29:26 plus 1.
- R5: Otherwise the processor frequency is q × 1024, kept to its low 32 bits. Here q = 2 × (ref >> 10) × (factor × denominator + numerator) / (denominator × pre-divider). The product is evaluated in 48-bit signed arithmetic and the division truncates toward zero.
- R6: The high-speed frequency is the processor frequency divided by (1 + post-divider bits 13:11), truncated.
- R7: The bus frequency is the high-speed frequency divided by (1 + post-divider bits 7:6), truncated.
- R8: A start pulse while idle captures all three control words. `busy` is high from the next cycle. Later changes of the words have no effect on that calculation.
- R9: A start pulse while `busy` is high is ignored: there is no restart and no extra done pulse.
- R10: `done` is high for exactly one cycle, with `busy` low and all three outputs valid. The high-speed and bus outputs hold their values while the unit is idle.
- R11: With mode word 0x074B0B7B, PLL word 0x04001800 and post-divider word 0xFF870B48, the outputs are 155,996,160, 77,998,080 and 38,999,040 Hz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to compute from the current words |
| mode_reg | input | 32 | Mode word: reference select, PLL enable, bypass |
| pll_reg | input | 32 | Main PLL control word |
| div_reg | input | 32 | Post-divider word |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse, results valid |
| cpu_hz | output | 32 | Processor clock frequency in Hz |
| hs_hz | output | 32 | High-speed clock frequency in Hz |
| bus_hz | output | 32 | Peripheral bus clock frequency in Hz |

## Verification
Any state error comes out at the ports within one calculation, which is roughly 150 cycles. A wrong sequencer state or a lost divider load shows up either as a done pulse that never arrives or as a second done pulse. A corrupted remainder or quotient bit gives values that miss the arithmetic model, and because the dividers are chained the error spreads into the high-speed and bus outputs as well. Sweeping the reference select, the bypass forms, the clamp, the numerator sign and every post-divider setting drives each datapath branch into an output that the bench compares.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int RES_W      = 32;
    localparam int ACC_W      = 48;
    localparam int FRAC_SHIFT = 10;

    localparam logic [RES_W-1:0] REF_HI_HZ = 32'd26000000;
    localparam logic [RES_W-1:0] REF_LO_HZ = 32'd33554432;

    // mode word bit positions
    localparam int             MODE_SEL_LSB  = 1;
    localparam logic [1:0]     MODE_SEL_LOW  = 2'd2;
    localparam int             MODE_PLL_EN   = 3;
    localparam int             MODE_BYPASS   = 7;

    // PLL word field widths and positions
    localparam int             NUM_W   = 10;
    localparam int             NUM_LSB = 0;
    localparam int             INT_W   = 4;
    localparam int             INT_LSB = 10;
    localparam int             DEN_W   = 10;
    localparam int             DEN_LSB = 16;
    localparam int             PRE_W   = 4;
    localparam int             PRE_LSB = 26;
    localparam logic [INT_W-1:0] INT_MIN = 4'd5;

    // post-divider word
    localparam int HS_W    = 3;
    localparam int HS_LSB  = 11;
    localparam int BUS_W   = 2;
    localparam int BUS_LSB = 6;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PLL  = 2'd1,
        S_HS   = 2'd2,
        S_BUS  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [RES_W-1:0] ref_hz;
        logic             bypass;
        logic             neg;
        logic [ACC_W-1:0] mag;
        logic [ACC_W-1:0] den;
        logic [HS_W:0]    hs_div;
        logic [BUS_W:0]   bus_div;
    } calc_cfg_t;

    function automatic logic [RES_W-1:0] pick_ref(input logic [RES_W-1:0] mode);
        return (mode[MODE_SEL_LSB +: 2] == MODE_SEL_LOW) ? REF_LO_HZ : REF_HI_HZ;
    endfunction

    function automatic logic [INT_W-1:0] clamp_int(input logic [INT_W-1:0] raw);
        return (raw < INT_MIN) ? INT_MIN : raw;
    endfunction

endpackage

// File: rtl/pfc_decode.sv
module pfc_decode
    import pfc_pkg::*;
(
    input  logic [RES_W-1:0] mode_reg,
    input  logic [RES_W-1:0] pll_reg,
    input  logic [RES_W-1:0] div_reg,
    output calc_cfg_t        cfg
);
    logic [RES_W-1:0]        ref_hz;
    logic signed [ACC_W-1:0] ref_s, int_s, num_s, den_s, pre_s, term_s, prod_s;
    logic                    unused_bits;

    always_comb begin
        ref_hz = pick_ref(mode_reg);
        ref_s  = ACC_W'(ref_hz >> FRAC_SHIFT);
        int_s  = ACC_W'(clamp_int(pll_reg[INT_LSB +: INT_W]));
        num_s  = {{(ACC_W-NUM_W){pll_reg[NUM_LSB+NUM_W-1]}}, pll_reg[NUM_LSB +: NUM_W]};
        den_s  = ACC_W'(pll_reg[DEN_LSB +: DEN_W]) + ACC_W'(1);
        pre_s  = ACC_W'(pll_reg[PRE_LSB +: PRE_W]) + ACC_W'(1);
        term_s = int_s * den_s + num_s;
        prod_s = (ref_s * term_s) <<< 1;

        cfg.ref_hz  = ref_hz;
        cfg.bypass  = mode_reg[MODE_BYPASS] | ~mode_reg[MODE_PLL_EN];
        cfg.neg     = prod_s[ACC_W-1];
        cfg.mag     = prod_s[ACC_W-1] ? ACC_W'(-prod_s) : ACC_W'(prod_s);
        cfg.den     = ACC_W'(den_s * pre_s);
        cfg.hs_div  = {1'b0, div_reg[HS_LSB +: HS_W]} + (HS_W+1)'(1);
        cfg.bus_div = {1'b0, div_reg[BUS_LSB +: BUS_W]} + (BUS_W+1)'(1);
    end

    assign unused_bits = ^{mode_reg[31:8], mode_reg[6:4], mode_reg[0],
                           pll_reg[31:30], pll_reg[15:14],
                           div_reg[31:14], div_reg[10:8], div_reg[5:0]};

endmodule

// File: rtl/pfc_divider.sv
module pfc_divider #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         valid,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    trial;
    logic [W:0]    dsr_ext;

    assign trial   = {rem_q, quo_q[W-1]};
    assign dsr_ext = {1'b0, divisor};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (load) begin
                rem_q <= '0;
                quo_q <= dividend;
                cnt_q <= CW'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (trial >= dsr_ext) begin
                    rem_q <= W'(trial - dsr_ext);
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy  <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

endmodule

// File: rtl/pllfreq_calc.sv
module pllfreq_calc
    import pfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [RES_W-1:0] mode_reg,
    input  logic [RES_W-1:0] pll_reg,
    input  logic [RES_W-1:0] div_reg,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] cpu_hz,
    output logic [RES_W-1:0] hs_hz,
    output logic [RES_W-1:0] bus_hz
);
    seq_state_t       state_q;
    calc_cfg_t        cfg_d, cfg_q;
    logic             kick_q;
    logic [ACC_W-1:0] dvd, dsr, div_quo, signed_q;
    logic             div_busy, div_valid;
    logic [RES_W-1:0] cpu_scaled;
    logic             unused_top;

    pfc_decode u_dec (
        .mode_reg (mode_reg),
        .pll_reg  (pll_reg),
        .div_reg  (div_reg),
        .cfg      (cfg_d)
    );

    always_comb begin
        unique case (state_q)
            S_PLL: begin
                dvd = cfg_q.mag;
                dsr = cfg_q.den;
            end
            S_HS: begin
                dvd = ACC_W'(cpu_hz);
                dsr = ACC_W'(cfg_q.hs_div);
            end
            S_BUS: begin
                dvd = ACC_W'(hs_hz);
                dsr = ACC_W'(cfg_q.bus_div);
            end
            default: begin
                dvd = '0;
                dsr = ACC_W'(1);
            end
        endcase
    end

    pfc_divider #(.W(ACC_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (kick_q),
        .dividend (dvd),
        .divisor  (dsr),
        .busy     (div_busy),
        .valid    (div_valid),
        .quotient (div_quo)
    );

    assign signed_q   = cfg_q.neg ? (~div_quo + ACC_W'(1)) : div_quo;
    assign cpu_scaled = {signed_q[RES_W-FRAC_SHIFT-1:0], {FRAC_SHIFT{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cfg_q   <= '0;
            kick_q  <= 1'b0;
            done    <= 1'b0;
            cpu_hz  <= '0;
            hs_hz   <= '0;
            bus_hz  <= '0;
        end else begin
            kick_q <= 1'b0;
            done   <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    cfg_q  <= cfg_d;
                    kick_q <= 1'b1;
                    if (cfg_d.bypass) begin
                        cpu_hz  <= cfg_d.ref_hz;
                        state_q <= S_HS;
                    end else begin
                        state_q <= S_PLL;
                    end
                end
                S_PLL: if (div_valid) begin
                    cpu_hz  <= cpu_scaled;
                    kick_q  <= 1'b1;
                    state_q <= S_HS;
                end
                S_HS: if (div_valid) begin
                    hs_hz   <= div_quo[RES_W-1:0];
                    kick_q  <= 1'b1;
                    state_q <= S_BUS;
                end
                S_BUS: if (div_valid) begin
                    bus_hz  <= div_quo[RES_W-1:0];
                    done    <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != S_IDLE);
    assign unused_top = ^{signed_q[ACC_W-1:RES_W-FRAC_SHIFT], div_busy};

endmodule

// File: rtl/pllfreq_calc_chk.sv
module pllfreq_calc_chk
    import pfc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [RES_W-1:0] mode_reg,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] cpu_hz,
    input logic [RES_W-1:0] hs_hz,
    input logic [RES_W-1:0] bus_hz
);
    logic [RES_W-1:0] mode_cap;
    logic             byp_cap;
    logic [RES_W-1:0] ref_cap;

    always_ff @(posedge clk) begin
        if (rst) mode_cap <= '0;
        else if (start && !busy) mode_cap <= mode_reg;
    end

    assign byp_cap = mode_cap[MODE_BYPASS] | ~mode_cap[MODE_PLL_EN];
    assign ref_cap = pick_ref(mode_cap);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(hs_hz) && $stable(bus_hz)));
    a_r3_bypass_ref: assert property (@(posedge clk) disable iff (rst)
        (done && byp_cap) |-> (cpu_hz == ref_cap));
    a_r6_hs_not_above: assert property (@(posedge clk) disable iff (rst)
        done |-> (hs_hz <= cpu_hz));
    a_r7_bus_not_above: assert property (@(posedge clk) disable iff (rst)
        done |-> (bus_hz <= hs_hz));

endmodule

bind pllfreq_calc pllfreq_calc_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode_reg (mode_reg),
    .busy     (busy),
    .done     (done),
    .cpu_hz   (cpu_hz),
    .hs_hz    (hs_hz),
    .bus_hz   (bus_hz)
);

// File: tb/pllfreq_calc_tb_top.sv
module pllfreq_calc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] mode_reg = '0, pll_reg = '0, div_reg = '0;
    logic        busy, done;
    logic [31:0] cpu_hz, hs_hz, bus_hz;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pllfreq_calc dut_i (
        .clk(clk), .rst(rst), .start(start),
        .mode_reg(mode_reg), .pll_reg(pll_reg), .div_reg(div_reg),
        .busy(busy), .done(done),
        .cpu_hz(cpu_hz), .hs_hz(hs_hz), .bus_hz(bus_hz)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Arithmetic model from the requirements (R2..R7)
    function automatic void model(input logic [31:0] m, input logic [31:0] p,
                                  input logic [31:0] d, output logic [31:0] c,
                                  output logic [31:0] h, output logic [31:0] b);
        longint refv, fi, fn, fd, pd, num, q;
        refv = (m[2:1] == 2'd2) ? 64'd33554432 : 64'd26000000;   // R2
        if (m[7] || !m[3]) begin                                     // R3
            c = refv[31:0];
        end else begin
            fi = longint'(p[13:10]);                                 // R4
            if (fi < 5) fi = 5;
            fn = longint'(signed'(p[9:0]));
            fd = longint'(p[25:16]) + 1;
            pd = longint'(p[29:26]) + 1;
            num = 2 * (refv >>> 10) * (fi * fd + fn);
            q = num / (fd * pd);                                     // R5
            c = 32'(q * 1024);
        end
        h = c / (32'd1 + 32'(d[13:11]));                             // R6
        b = h / (32'd1 + 32'(d[7:6]));                               // R7
    endfunction

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_calc(input logic [31:0] m, input logic [31:0] p,
                            input logic [31:0] d, input string tag);
        logic [31:0] ec, eh, eb;
        bit seen;
        model(m, p, d, ec, eh, eb);
        mode_reg = m; pll_reg = p; div_reg = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {"R8 busy ", tag}, 32'(busy), 1);
        wait_done(seen);
        check(seen, {"R10 done ", tag}, 32'(seen), 1);
        check(cpu_hz == ec, {"R5 cpu ", tag}, cpu_hz, ec);
        check(hs_hz == eh, {"R6 hs ", tag}, hs_hz, eh);
        check(bus_hz == eb, {"R7 bus ", tag}, bus_hz, eb);
        @(negedge clk);
        check(done == 1'b0, {"R10 one-cycle ", tag}, 32'(done), 0);
    endtask

    initial begin
        logic [31:0] ec, eh, eb;
        bit seen;
        int ndone;
        int mfn_set[6] = '{0, 1, 511, 512, 1023, 300};
        int mfd_set[4] = '{0, 1, 4, 1023};
        int pd_set[3]  = '{0, 1, 15};
        int mfi_set[5] = '{0, 4, 5, 6, 15};
        int k;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && done == 1'b0, "R1 flags", {30'd0, busy, done}, 0);
        check(cpu_hz == 0 && hs_hz == 0 && bus_hz == 0, "R1 outputs", cpu_hz | hs_hz | bus_hz, 0);

        // R11: reset register values
        run_calc(32'h074B0B7B, 32'h04001800, 32'hFF870B48, "R11");
        check(cpu_hz == 32'd155996160, "R11 cpu", cpu_hz, 32'd155996160);
        check(hs_hz == 32'd77998080, "R11 hs", hs_hz, 32'd77998080);
        check(bus_hz == 32'd38999040, "R11 bus", bus_hz, 32'd38999040);

        // R2 R3: bypass forms for both references, all post-divider settings (R6 R7)
        for (int sel = 0; sel < 2; sel++) begin
            for (int form = 0; form < 2; form++) begin
                for (int dv = 0; dv < 32; dv++) begin
                    logic [31:0] m;
                    m = (form == 0) ? 32'h0000_0088 : 32'h0000_0000;
                    if (sel == 1) m = m | 32'h0000_0004;
                    run_calc(m, 32'h1234_5678, (32'(dv[2:0]) << 11) | (32'(dv[4:3]) << 6),
                             "R3 bypass");
                end
            end
        end

        // R4 R5: PLL sweep over clamp, numerator sign, denominator, pre-divider
        k = 0;
        for (int sel = 0; sel < 2; sel++)
            for (int a = 0; a < 5; a++)
                for (int b = 0; b < 6; b++)
                    for (int c = 0; c < 4; c++)
                        for (int e = 0; e < 3; e++) begin
                            logic [31:0] p, m;
                            m = (sel == 1) ? 32'h0000_000C : 32'h0000_0008;
                            p = (32'(pd_set[e] & 15) << 26) | (32'(mfd_set[c] & 1023) << 16)
                              | (32'(mfi_set[a] & 15) << 10) | 32'(mfn_set[b] & 1023);
                            run_calc(m, p, (32'(k % 8) << 11) | (32'((k / 8) % 4) << 6), "R4 pll");
                            k++;
                        end

        // R8 R9: inputs changed and start repeated during busy
        model(32'h0000_0008, 32'h0000_1800, 32'h0000_0000, ec, eh, eb);
        mode_reg = 32'h0000_0008; pll_reg = 32'h0000_1800; div_reg = 32'h0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        mode_reg = 32'h0000_0088; pll_reg = 32'h3FFF_FFFF; div_reg = 32'hFFFF_FFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        check(seen, "R9 done", 32'(seen), 1);
        check(cpu_hz == ec, "R8 cpu captured", cpu_hz, ec);
        check(bus_hz == eb, "R9 bus unaffected", bus_hz, eb);
        ndone = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        check(ndone == 0, "R9 no extra done", ndone, 0);
        check(busy == 1'b0, "R9 idle", 32'(busy), 0);
        check(hs_hz == eh, "R10 hold hs", hs_hz, eh);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule